// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes a first operand, a second operand that is either a register value or an immediate, and a 4-bit operation code. From these it forms an 8-bit result and a result-write strobe without any clock delay. The status byte is registered. It holds the half-carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C) flags. The two top bits are held but are never written by this block.

The flags that an operation is allowed to change are fixed for each operation code. When an operation code is applied with the enable high, only those flags are replaced at the next rising clock edge, and every other bit keeps its value. Subtract-with-carry and compare-with-carry can only keep or clear Z, never set it. This lets software compare or subtract values wider than one byte, one byte at a time.

Top module: `alu8_status_core`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises, status reads 0x00. Status bit layout from bit 7 down to bit 0 is: held bit, held bit, H, S, V, N, Z, C.
- R2: Add (code 0) forms opa+b and add-with-carry (code 1) forms opa+b+C. Both update H (carry out of bit 3), V (signed overflow), N (result bit 7), Z (result zero) and C (carry out of bit 7).
- R3: Subtract (code 2) forms opa−b and subtract-with-carry (code 3) forms opa−b−C. Operand b is imm when use_imm is 1 and opb otherwise, for every code that reads b.
- R4: For every subtracting code, C is the borrow out of bit 7, H is the borrow out of bit 3, and V is the signed overflow of the difference.
- R5: For codes 3 and 13, Z becomes 1 only if the result is zero and Z was already 1. Otherwise Z becomes 0.
- R6: AND (code 4), OR (code 5), XOR (code 6) and AND-with-inverted-b (code 7) update only Z, N, S and V, with V forced to 0. H and C are kept.
- R7: Increment (code 10) and decrement (code 11) act on opa alone and update Z, N, V and S. H and C are kept.
- R8: One's complement (code 8) returns 0xFF−opa and sets C to 1 and V to 0. It updates Z, N and S and keeps H.
- R9: Two's complement (code 9) returns 0x00−opa and updates H, S, V, N, Z and C with the subtraction rules.
- R10: Compare (code 12) and compare-with-carry (code 13) set the flags exactly as codes 2 and 3 would, but result_we stays 0.
- R11: Set-all (code 14) returns 0xFF with result_we=1 and leaves the whole status byte unchanged.
- R12: Whenever N or V is updated, S takes the value N XOR V.
- R13: Status bits 7 and 6 never change.
- R14: With op_en low, status is unchanged at the next edge. Code 15 returns 0x00 with result_we=0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the status byte |
| op_en | input | 1 | Commit the flag update of the present operation |
| op_sel | input | 4 | Operation code |
| opa | input | 8 | First operand (register) |
| opb | input | 8 | Second operand (register) |
| imm | input | 8 | Immediate second operand |
| use_imm | input | 1 | Select imm instead of opb as second operand |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result is to be written back |
| status | output | 8 | Registered status byte |

## Verification
A fixed table of operand pairs drives each kind of operation across the byte boundaries: 0xFF+1, 0x7F+1, 0x00−1, 0x80 negated, and the nibble carries and borrows. These cases separate the carry and borrow bits from the signed overflow and from the half-carry. Random operands are then applied over all sixteen codes. The carry that each operation reads is left as the previous operation produced it, so both carry-in values are covered and each flag mask is compared with a model that computes with integers. Directed sequences then cover two-byte equal and unequal compares, where a zero flag that is kept and a zero flag that is cleared give different outcomes, and also the immediate select with a conflicting opb, an idle enable, and the reserved code.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADC    = 4'd1,
    OP_SUB    = 4'd2,
    OP_SBC    = 4'd3,
    OP_AND    = 4'd4,
    OP_OR     = 4'd5,
    OP_XOR    = 4'd6,
    OP_ANDN   = 4'd7,
    OP_COM    = 4'd8,
    OP_NEG    = 4'd9,
    OP_INC    = 4'd10,
    OP_DEC    = 4'd11,
    OP_CMP    = 4'd12,
    OP_CMPC   = 4'd13,
    OP_SETALL = 4'd14,
    OP_NONE   = 4'd15
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  localparam logic [7:0] MASK_ARITH = 8'b0011_1111;
  localparam logic [7:0] MASK_LOGIC = 8'b0001_1110;
  localparam logic [7:0] MASK_COMP  = 8'b0001_1111;
  localparam logic [7:0] MASK_NONE  = 8'b0000_0000;

  function automatic logic [7:0] flag_mask(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_NEG, OP_CMP, OP_CMPC:          return MASK_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_ANDN,
      OP_INC, OP_DEC:                   return MASK_LOGIC;
      OP_COM:                           return MASK_COMP;
      default:                          return MASK_NONE;
    endcase
  endfunction

  function automatic logic writes_result(alu_op_e op);
    return !(op == OP_CMP || op == OP_CMPC || op == OP_NONE);
  endfunction

endpackage

// File: rtl/alu8_operand_sel.sv
module alu8_operand_sel
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] b_eff,
  input  logic             carry_flag,
  output logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y,
  output logic             cin,
  output logic             is_sub
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = '0;

  always_comb begin
    x      = opa;
    y      = b_eff;
    cin    = 1'b0;
    is_sub = 1'b0;
    case (op)
      OP_ADC:          cin = carry_flag;
      OP_SUB, OP_CMP:  is_sub = 1'b1;
      OP_SBC, OP_CMPC: begin is_sub = 1'b1; cin = carry_flag; end
      OP_NEG:          begin x = ZERO; y = opa; is_sub = 1'b1; end
      OP_INC:          y = ONE;
      OP_DEC:          begin y = ONE; is_sub = 1'b1; end
      default:         ;
    endcase
  end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  input  logic             is_sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             hout,
  output logic             vout
);
  localparam int HW = WIDTH / 2;

  function automatic logic [WIDTH:0] wide_op(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                                             logic c, logic sub);
    logic [WIDTH:0] ea, eb, ec;
    ea = {1'b0, a};
    eb = {1'b0, b};
    ec = {{WIDTH{1'b0}}, c};
    return sub ? (ea - eb - ec) : (ea + eb + ec);
  endfunction

  function automatic logic [HW:0] nib_op(logic [HW-1:0] a, logic [HW-1:0] b,
                                         logic c, logic sub);
    logic [HW:0] ea, eb, ec;
    ea = {1'b0, a};
    eb = {1'b0, b};
    ec = {{HW{1'b0}}, c};
    return sub ? (ea - eb - ec) : (ea + eb + ec);
  endfunction

  function automatic logic sign_ovf(logic sa, logic sb, logic sr, logic sub);
    return sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  endfunction

  logic [WIDTH:0] full;
  logic [HW:0]    nib;

  always_comb begin
    full = wide_op(x, y, cin, is_sub);
    nib  = nib_op(x[HW-1:0], y[HW-1:0], cin, is_sub);
    sum  = full[WIDTH-1:0];
    cout = full[WIDTH];
    hout = nib[HW];
    vout = sign_ovf(x[WIDTH-1], y[WIDTH-1], full[WIDTH-1], is_sub);
  end
endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] r
);
  always_comb begin
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_ANDN: r = a & ~b;
      OP_COM:  r = ~a;
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] mask,
  input  logic [7:0] cand,
  output logic [7:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n)  status <= 8'h00;
    else if (en) status <= (status & ~mask) | (cand & mask);
  end
endmodule

// File: rtl/alu8_status_core.sv
module alu8_status_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_en,
  input  logic [3:0] op_sel,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic [7:0] imm,
  input  logic       use_imm,
  output logic [7:0] result,
  output logic       result_we,
  output logic [7:0] status
);
  localparam int WIDTH = 8;

  alu_op_e          op;
  logic [WIDTH-1:0] b_eff, x, y, arith_r, logic_r;
  logic             cin, is_sub, a_c, a_h, a_v;
  logic             is_logic, is_arith, z_chain, raw_zero;
  logic [7:0]       cand, mask;

  assign op    = alu_op_e'(op_sel);
  assign b_eff = use_imm ? imm : opb;

  alu8_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .op(op), .opa(opa), .b_eff(b_eff), .carry_flag(status[FL_C]),
    .x(x), .y(y), .cin(cin), .is_sub(is_sub)
  );

  alu8_addsub #(.WIDTH(WIDTH)) u_add (
    .x(x), .y(y), .cin(cin), .is_sub(is_sub),
    .sum(arith_r), .cout(a_c), .hout(a_h), .vout(a_v)
  );

  alu8_logic_unit #(.WIDTH(WIDTH)) u_log (
    .op(op), .a(opa), .b(b_eff), .r(logic_r)
  );

  assign is_logic = (op inside {OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_COM});
  assign is_arith = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
                                OP_INC, OP_DEC, OP_CMP, OP_CMPC});
  assign z_chain  = (op == OP_SBC) || (op == OP_CMPC);

  always_comb begin
    if (op == OP_SETALL) result = 8'hFF;
    else if (is_logic)   result = logic_r;
    else if (is_arith)   result = arith_r;
    else                 result = 8'h00;
  end

  assign result_we = writes_result(op);
  assign mask      = flag_mask(op);
  assign raw_zero  = (result == 8'h00);

  always_comb begin
    cand       = status;
    cand[FL_N] = result[7];
    cand[FL_Z] = z_chain ? (raw_zero & status[FL_Z]) : raw_zero;
    cand[FL_V] = is_logic ? 1'b0 : a_v;
    cand[FL_C] = (op == OP_COM) ? 1'b1 : a_c;
    cand[FL_H] = a_h;
    cand[FL_S] = cand[FL_N] ^ cand[FL_V];
  end

  alu8_status_reg u_st (
    .clk(clk), .rst_n(rst_n), .en(op_en), .mask(mask), .cand(cand), .status(status)
  );
endmodule

// File: rtl/alu8_status_core_chk.sv
module alu8_status_core_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_en,
  input logic [3:0] op_sel,
  input logic       result_we,
  input logic [7:0] status
);
  AST_HELD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    op_en |=> $stable(status[7:6])); // R13
  AST_SETALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == OP_SETALL) |=> (status == $past(status))); // R11
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(status)); // R14
  AST_S_IS_NXORV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel != OP_SETALL && op_sel != OP_NONE) |=> (status[4] == (status[2] ^ status[3]))); // R12
  AST_LOGIC_VZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel inside {OP_AND, OP_OR, OP_XOR, OP_ANDN}) |=> !status[3]); // R6
  AST_INCDEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel inside {OP_INC, OP_DEC}) |=> (status[5] == $past(status[5]) && status[0] == $past(status[0]))); // R7
  AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP || op_sel == OP_CMPC) |-> !result_we); // R10
  AST_CHAIN_ZSTAY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel inside {OP_SBC, OP_CMPC} && !status[1]) |=> !status[1]); // R5
  AST_COM_CSET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == OP_COM) |=> status[0]); // R8
endmodule

bind alu8_status_core alu8_status_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
  .result_we(result_we), .status(status)
);

// File: tb/alu8_status_core_test.sv
module alu8_status_core_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [3:0] op_sel = 4'd15;
  logic [7:0] opa = '0, opb = '0, imm = '0;
  logic       use_imm = 1'b0;
  logic [7:0] result, status;
  logic       result_we;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_st = 8'h00;

  always #(PERIOD/2) clk = ~clk;

  alu8_status_core uut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel), .opa(opa),
    .opb(opb), .imm(imm), .use_imm(use_imm), .result(result),
    .result_we(result_we), .status(status)
  );

  // {op, a, b, expected result}
  localparam logic [27:0] VEC [14] = '{
    {4'd0,  8'h3A, 8'hC6, 8'h00},
    {4'd0,  8'h7F, 8'h01, 8'h80},
    {4'd2,  8'h10, 8'h01, 8'h0F},
    {4'd2,  8'h00, 8'h01, 8'hFF},
    {4'd4,  8'hF0, 8'h3C, 8'h30},
    {4'd5,  8'hF0, 8'h0F, 8'hFF},
    {4'd6,  8'hAA, 8'hFF, 8'h55},
    {4'd7,  8'hFF, 8'h81, 8'h7E},
    {4'd8,  8'h5A, 8'h00, 8'hA5},
    {4'd9,  8'h01, 8'h00, 8'hFF},
    {4'd9,  8'h80, 8'h00, 8'h80},
    {4'd10, 8'hFF, 8'h00, 8'h00},
    {4'd11, 8'h80, 8'h00, 8'h7F},
    {4'd14, 8'h12, 8'h34, 8'hFF}
  };

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:                     return "R2";
      4'd2, 4'd3:                     return "R3/R4";
      4'd4, 4'd5, 4'd6, 4'd7:         return "R6";
      4'd8:                           return "R8";
      4'd9:                           return "R9";
      4'd10, 4'd11:                   return "R7";
      4'd12, 4'd13:                   return "R10";
      4'd14:                          return "R11";
      default:                        return "R14";
    endcase
  endfunction

  // Integer reference model of one operation
  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] st, output logic [7:0] r, output logic we,
                       output logic [7:0] nst);
    int ia, ib, ci, d, sa, sb, sd;
    logic c, h, v;
    nst = st; we = 1'b1; r = 8'h00; c = 0; h = 0; v = 0;
    if (op inside {4'd0, 4'd1, 4'd10}) begin
      ia = a; ib = (op == 4'd10) ? 1 : int'(b); ci = (op == 4'd1) ? int'(st[0]) : 0;
      d = ia + ib + ci; r = d[7:0];
      c = d > 255; h = ((ia % 16) + (ib % 16) + ci) > 15;
      sa = int'($signed(a)); sb = (op == 4'd10) ? 1 : int'($signed(b));
      sd = sa + sb + ci; v = (sd > 127) || (sd < -128);
    end else if (op inside {4'd2, 4'd3, 4'd9, 4'd11, 4'd12, 4'd13}) begin
      ia = (op == 4'd9) ? 0 : int'(a);
      ib = (op == 4'd9) ? int'(a) : ((op == 4'd11) ? 1 : int'(b));
      ci = (op == 4'd3 || op == 4'd13) ? int'(st[0]) : 0;
      d = ia - ib - ci; r = d[7:0];
      c = d < 0; h = ((ia % 16) - (ib % 16) - ci) < 0;
      sa = (op == 4'd9) ? 0 : int'($signed(a));
      sb = (op == 4'd9) ? int'($signed(a)) : ((op == 4'd11) ? 1 : int'($signed(b)));
      sd = sa - sb - ci; v = (sd > 127) || (sd < -128);
    end
    case (op)
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = a & ~b;
      4'd8: r = 8'hFF - a;
      4'd14: r = 8'hFF;
      4'd15: r = 8'h00;
      default: ;
    endcase
    if (op == 4'd12 || op == 4'd13 || op == 4'd15) we = 1'b0;
    if (op inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd8}) v = 1'b0;
    if (op == 4'd8) c = 1'b1;
    if (op <= 4'd13) begin
      nst[2] = r[7];
      nst[3] = v;
      nst[4] = r[7] ^ v;
      nst[1] = (op == 4'd3 || op == 4'd13) ? ((r == 8'h00) && st[1]) : (r == 8'h00);
      if (!(op inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11})) nst[0] = c;
      if (!(op inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11})) nst[5] = h;
    end
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [3:0] op, logic [7:0] a, logic [7:0] b,
                       logic [7:0] im, logic ui, logic en);
    logic [7:0] r, nst;
    logic we;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; imm = im; use_imm = ui; op_en = en;
    model(op, a, ui ? im : b, exp_st, r, we, nst);
    if (!en) nst = exp_st;
    #1;
    check8({tag, " result"}, result, r);
    check8({tag, " result_we"}, {7'd0, result_we}, {7'd0, we});
    @(posedge clk);
    #1;
    check8({tag, " status"}, status, nst);
    exp_st = nst;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check8("R1 status in reset", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check8("R1 status after reset", status, 8'h00);

    // table of vectors
    for (int i = 0; i < 14; i++) begin
      logic [3:0] vop;
      vop = VEC[i][27:24];
      apply(req_of(vop), vop, VEC[i][23:16], VEC[i][15:8], 8'h00, 1'b0, 1'b1);
      check8({req_of(vop), " table result"}, result, VEC[i][7:0]);
    end

    // R3 immediate select with conflicting opb
    apply("R3 imm", 4'd2, 8'h20, 8'hAA, 8'h05, 1'b1, 1'b1);
    check8("R3 imm value", result, 8'h1B);

    // R5 two-byte equal compare keeps Z
    apply("R5 lo", 4'd12, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    apply("R5 hi", 4'd13, 8'h01, 8'h01, 8'h00, 1'b0, 1'b1);
    check8("R5 Z kept", {7'd0, status[1]}, 8'h01);
    // R5 low bytes differ: Z cleared, stays cleared
    apply("R5 lo2", 4'd12, 8'h05, 8'h04, 8'h00, 1'b0, 1'b1);
    apply("R5 hi2", 4'd13, 8'h01, 8'h01, 8'h00, 1'b0, 1'b1);
    check8("R5 Z not set", {7'd0, status[1]}, 8'h00);

    // R11 set-all after flags set, R14 idle and reserved code
    apply("R11 prep", 4'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b1);
    apply("R11 setall", 4'd14, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    apply("R14 idle", 4'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
    apply("R14 reserved", 4'd15, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1);

    // Random sweep, carry-in left from the previous operation (R12, R13 via status)
    for (int k = 0; k < 600; k++) begin
      logic [3:0] rop;
      rop = 4'($urandom % 16);
      apply({req_of(rop), " R12 R13 random"}, rop, 8'($urandom), 8'($urandom),
            8'($urandom), 1'($urandom), ($urandom % 8) != 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule